// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects up to 48 level-sensitive interrupt lines, organised as six groups of eight members (two groups serve a pair of RISC engines, four serve general peripherals), and drives two processor request lines: a high-urgency request and a normal request. Each request line has its own vector register that names the winning pending source, so the interrupt handler reads one word and knows which source to serve.

Priority is programmed per group rather than per source. Each group owns a register of eight ordered slots, and each slot holds the 3-bit member code of the group member placed there. Between groups, a fixed order applies. A group can instead join a "spread" pool, where groups compete by slot rank. The two best slots of every group can be steered to the high request line. A separate override names any single source, puts it ahead of everything else, and sends it to the output of its choice. Software configures the block through a simple 32-bit word-addressed register port.

Top module: `qgic_top`

## Requirements
- R1: After a synchronous reset, the configuration, both mask registers and the routing register read 0. Every slot register reads with slot p (0-based) holding member code p. Both vectors read 0 and both request outputs are low.
- R2: Source number g*8+m+1 (group g, member m) is pending only while its input bit src_i[g*8+m] is 1 and its enable bit is 1. Groups 0 and 1 are enabled by bit g*8+m of the RISC mask register (word 2). Groups 2 to 5 are enabled by bit (g-2)*8+m of the main mask register (word 1). A masked source is never reported.
- R3: The low vector (word 10) and the high vector (word 11) carry the winning source number in bits 31:26, with all other bits 0. When no source is pending for an output, its vector is 0 and its request is low.
- R4: Slot registers are words 4+g. Slot p (1 to 8) of a group holds a member code in bits [34-3p:32-3p]. A member's rank is the first slot that names it. Within a group, the lowest-numbered slot whose member is pending wins. A member named in no slot is never reported.
- R5: Groups in grouped mode (the default) are served in the fixed order 0,1,2,3,4,5. All grouped-mode groups are ahead of any spread-mode group.
- R6: Configuration bit 16+g places group g in spread mode. Spread-mode groups compete by the slot number of their best candidate. Equal slots are resolved by the lower group index.
- R7: Routing register (word 3) bits [4g+3:4g+2] steer slot 1 of group g, and bits [4g+1:4g] steer slot 2. The value 2'b10 sends that slot's member to the high output. Any other value, and every slot from 3 to 8, goes to the low output.
- R8: Configuration bits 5:0 name an override source; 0 or a value above 48 means none. Bits 9:8 equal to 2'b10 send the override to the high output; any other value sends it to the low output. A pending override wins its output ahead of all other sources and never appears through its group's slot routing.
- R9: A register write changes arbitration from the next clock edge. The request outputs and vectors update on the clock edge after the pending set changes. Read data is returned one cycle after the address is presented.
- R10: A request stays asserted for as long as its source stays asserted and unmasked. It is removed on the clock edge after the source drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 48 | Level interrupt inputs, bit g*8+m |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_hi_o | output | 1 | High-urgency request |
| irq_lo_o | output | 1 | Normal request |

## Verification
The high and low outputs are arbitrated in the same cycle from one pending set. The bench therefore drives a group whose slot 1 is steered high while its slot 2 member, and sometimes a differently routed override, are pending at the same time. It then reads both vectors and checks that each output gets its own winner and that no source shows on both. Randomised rounds combine random masks, slot orders, routing, spread bits and overrides, and compare each vector against a bench model built from the requirements.

// File: rtl/qgic_pkg.sv
package qgic_pkg;
  // register word addresses
  localparam int ADDR_CFG       = 0;
  localparam int ADDR_MASK_MAIN = 1;
  localparam int ADDR_MASK_RISC = 2;
  localparam int ADDR_ROUTE     = 3;
  localparam int ADDR_SLOT_BASE = 4;
  // configuration word layout
  localparam int CFG_SEL_LSB    = 8;
  localparam int CFG_SPREAD_LSB = 16;
  // per-group routing bits: slot 1 select above slot 2 select
  localparam int ROUTE_BITS     = 4;
  localparam logic [1:0] SEL_HIGH = 2'b10;
endpackage

// File: rtl/qgic_regs.sv
module qgic_regs
  import qgic_pkg::*;
#(
  parameter int GROUPS      = 6,
  parameter int MEMBERS     = 8,
  parameter int RISC_GROUPS = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int VEC_W       = 6,
  localparam int CODE_W     = $clog2(MEMBERS),
  localparam int SLOT_W     = CODE_W * MEMBERS,
  localparam int MAIN_W     = (GROUPS - RISC_GROUPS) * MEMBERS,
  localparam int RISC_W     = RISC_GROUPS * MEMBERS,
  localparam int ROUTE_W    = ROUTE_BITS * GROUPS
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [VEC_W-1:0]               vec_lo_i,
  input  logic [VEC_W-1:0]               vec_hi_i,
  output logic [VEC_W-1:0]               ovr_num_o,
  output logic [1:0]                     ovr_sel_o,
  output logic [GROUPS-1:0]              spread_o,
  output logic [MAIN_W-1:0]              mask_main_o,
  output logic [RISC_W-1:0]              mask_risc_o,
  output logic [ROUTE_W-1:0]             route_o,
  output logic [GROUPS-1:0][SLOT_W-1:0]  slots_o,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int VEC_LO_ADDR = ADDR_SLOT_BASE + GROUPS;
  localparam int VEC_HI_ADDR = VEC_LO_ADDR + 1;

  function automatic logic [SLOT_W-1:0] slot_identity();
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int p = 0; p < MEMBERS; p++)
      r[SLOT_W - CODE_W*(p+1) +: CODE_W] = CODE_W'(p);
    return r;
  endfunction

  logic [DATA_W-1:0] rd_next;
  int                a;

  assign a = int'(addr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ovr_num_o   <= '0;
      ovr_sel_o   <= '0;
      spread_o    <= '0;
      mask_main_o <= '0;
      mask_risc_o <= '0;
      route_o     <= '0;
      for (int g = 0; g < GROUPS; g++) slots_o[g] <= slot_identity();
    end else if (wr_i) begin
      if (a == ADDR_CFG) begin
        ovr_num_o <= wdata_i[VEC_W-1:0];
        ovr_sel_o <= wdata_i[CFG_SEL_LSB +: 2];
        spread_o  <= wdata_i[CFG_SPREAD_LSB +: GROUPS];
      end
      if (a == ADDR_MASK_MAIN) mask_main_o <= wdata_i[MAIN_W-1:0];
      if (a == ADDR_MASK_RISC) mask_risc_o <= wdata_i[RISC_W-1:0];
      if (a == ADDR_ROUTE)     route_o     <= wdata_i[ROUTE_W-1:0];
      for (int g = 0; g < GROUPS; g++)
        if (a == ADDR_SLOT_BASE + g) slots_o[g] <= wdata_i[DATA_W-1 -: SLOT_W];
    end
  end

  always_comb begin
    rd_next = '0;
    if (a == ADDR_CFG) begin
      rd_next[VEC_W-1:0]               = ovr_num_o;
      rd_next[CFG_SEL_LSB +: 2]        = ovr_sel_o;
      rd_next[CFG_SPREAD_LSB +: GROUPS] = spread_o;
    end
    if (a == ADDR_MASK_MAIN) rd_next[MAIN_W-1:0]  = mask_main_o;
    if (a == ADDR_MASK_RISC) rd_next[RISC_W-1:0]  = mask_risc_o;
    if (a == ADDR_ROUTE)     rd_next[ROUTE_W-1:0] = route_o;
    if (a == VEC_LO_ADDR)    rd_next[DATA_W-1 -: VEC_W] = vec_lo_i;
    if (a == VEC_HI_ADDR)    rd_next[DATA_W-1 -: VEC_W] = vec_hi_i;
    for (int g = 0; g < GROUPS; g++)
      if (a == ADDR_SLOT_BASE + g) rd_next[DATA_W-1 -: SLOT_W] = slots_o[g];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_next;
  end
endmodule

// File: rtl/qgic_grp_arb.sv
module qgic_grp_arb
  import qgic_pkg::*;
#(
  parameter int MEMBERS  = 8,
  parameter bit HIGH_OUT = 1'b0,
  localparam int CODE_W  = $clog2(MEMBERS),
  localparam int SLOT_W  = CODE_W * MEMBERS
) (
  input  logic [MEMBERS-1:0]    pend_i,
  input  logic [MEMBERS-1:0]    excl_i,
  input  logic [SLOT_W-1:0]     slots_i,
  input  logic [ROUTE_BITS-1:0] route_i,
  output logic                  valid_o,
  output logic [CODE_W-1:0]     member_o,
  output logic [CODE_W-1:0]     slot_o
);
  // walk the slots from best to worst; a member only counts at its first slot
  always_comb begin
    logic [MEMBERS-1:0] seen;
    logic [CODE_W-1:0]  code;
    logic               to_hi;
    logic               found;
    seen     = '0;
    found    = 1'b0;
    member_o = '0;
    slot_o   = '0;
    for (int p = 0; p < MEMBERS; p++) begin
      code = slots_i[SLOT_W - CODE_W*(p+1) +: CODE_W];
      if (p == 0)      to_hi = (route_i[3:2] == SEL_HIGH);
      else if (p == 1) to_hi = (route_i[1:0] == SEL_HIGH);
      else             to_hi = 1'b0;
      if (!found && !seen[code] && pend_i[code] && !excl_i[code] &&
          (to_hi == HIGH_OUT)) begin
        found    = 1'b1;
        member_o = code;
        slot_o   = CODE_W'(p);
      end
      seen[code] = 1'b1;
    end
    valid_o = found;
  end
endmodule

// File: rtl/qgic_out_arb.sv
module qgic_out_arb #(
  parameter int GROUPS  = 6,
  parameter int MEMBERS = 8,
  parameter int VEC_W   = 6,
  localparam int CODE_W = $clog2(MEMBERS),
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int KEY_W  = 1 + GRP_W + CODE_W
) (
  input  logic [GROUPS-1:0]             grp_valid_i,
  input  logic [GROUPS-1:0][CODE_W-1:0] grp_member_i,
  input  logic [GROUPS-1:0][CODE_W-1:0] grp_slot_i,
  input  logic [GROUPS-1:0]             spread_i,
  input  logic                          ovr_valid_i,
  input  logic [VEC_W-1:0]              ovr_num_i,
  output logic                          valid_o,
  output logic [VEC_W-1:0]              num_o
);
  // grouped groups sort by group index, spread groups by slot then group
  always_comb begin
    logic             found;
    logic [KEY_W-1:0] key;
    logic [KEY_W-1:0] best_key;
    int               best_g;
    found    = 1'b0;
    best_key = '0;
    best_g   = 0;
    for (int g = 0; g < GROUPS; g++) begin
      if (spread_i[g]) key = {1'b1, grp_slot_i[g], GRP_W'(g)};
      else             key = {1'b0, GRP_W'(g), grp_slot_i[g]};
      if (grp_valid_i[g] && (!found || key < best_key)) begin
        found    = 1'b1;
        best_key = key;
        best_g   = g;
      end
    end
    if (ovr_valid_i) begin
      valid_o = 1'b1;
      num_o   = ovr_num_i;
    end else if (found) begin
      valid_o = 1'b1;
      num_o   = VEC_W'(best_g * MEMBERS + int'(grp_member_i[best_g]) + 1);
    end else begin
      valid_o = 1'b0;
      num_o   = '0;
    end
  end
endmodule

// File: rtl/qgic_top.sv
module qgic_top
  import qgic_pkg::*;
#(
  parameter int GROUPS      = 6,
  parameter int MEMBERS     = 8,
  parameter int RISC_GROUPS = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int VEC_W       = 6,
  localparam int NUM_SRC    = GROUPS * MEMBERS
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  localparam int CODE_W  = $clog2(MEMBERS);
  localparam int SLOT_W  = CODE_W * MEMBERS;
  localparam int MAIN_W  = (GROUPS - RISC_GROUPS) * MEMBERS;
  localparam int RISC_W  = RISC_GROUPS * MEMBERS;
  localparam int ROUTE_W = ROUTE_BITS * GROUPS;
  localparam int OUTS    = 2;   // index 0 = low request, 1 = high request

  logic [VEC_W-1:0]              ovr_num;
  logic [1:0]                    ovr_sel;
  logic [GROUPS-1:0]             spread;
  logic [MAIN_W-1:0]             mask_main;
  logic [RISC_W-1:0]             mask_risc;
  logic [ROUTE_W-1:0]            route;
  logic [GROUPS-1:0][SLOT_W-1:0] slots;
  logic [NUM_SRC-1:0]            enable;
  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0]            ovr_hit;
  logic                          ovr_pend;
  logic                          ovr_hi;
  logic [VEC_W-1:0]              vec_lo_q, vec_hi_q;
  logic                          irq_lo_q, irq_hi_q;

  logic [OUTS-1:0][GROUPS-1:0]             gv;
  logic [OUTS-1:0][GROUPS-1:0][CODE_W-1:0] gm;
  logic [OUTS-1:0][GROUPS-1:0][CODE_W-1:0] gs;
  logic [OUTS-1:0]                         win_valid;
  logic [OUTS-1:0][VEC_W-1:0]              win_num;

  qgic_regs #(
    .GROUPS(GROUPS), .MEMBERS(MEMBERS), .RISC_GROUPS(RISC_GROUPS),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .vec_lo_i    (vec_lo_q),
    .vec_hi_i    (vec_hi_q),
    .ovr_num_o   (ovr_num),
    .ovr_sel_o   (ovr_sel),
    .spread_o    (spread),
    .mask_main_o (mask_main),
    .mask_risc_o (mask_risc),
    .route_o     (route),
    .slots_o     (slots),
    .rdata_o     (bus_rdata_o)
  );

  // enable mapping: RISC groups from their own mask, the rest from the main mask
  for (genvar g = 0; g < GROUPS; g++) begin : g_en
    if (g < RISC_GROUPS) begin : g_risc
      assign enable[g*MEMBERS +: MEMBERS] = mask_risc[g*MEMBERS +: MEMBERS];
    end else begin : g_main
      assign enable[g*MEMBERS +: MEMBERS] = mask_main[(g-RISC_GROUPS)*MEMBERS +: MEMBERS];
    end
  end

  assign pend = src_i & enable;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ovr
    assign ovr_hit[i] = (int'(ovr_num) == i + 1);
  end

  assign ovr_pend = |(pend & ovr_hit);
  assign ovr_hi   = (ovr_sel == SEL_HIGH);

  for (genvar o = 0; o < OUTS; o++) begin : g_out
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      qgic_grp_arb #(
        .MEMBERS(MEMBERS), .HIGH_OUT(o == 1)
      ) u_grp (
        .pend_i   (pend[g*MEMBERS +: MEMBERS]),
        .excl_i   (ovr_hit[g*MEMBERS +: MEMBERS]),
        .slots_i  (slots[g]),
        .route_i  (route[g*ROUTE_BITS +: ROUTE_BITS]),
        .valid_o  (gv[o][g]),
        .member_o (gm[o][g]),
        .slot_o   (gs[o][g])
      );
    end
    qgic_out_arb #(
      .GROUPS(GROUPS), .MEMBERS(MEMBERS), .VEC_W(VEC_W)
    ) u_sel (
      .grp_valid_i  (gv[o]),
      .grp_member_i (gm[o]),
      .grp_slot_i   (gs[o]),
      .spread_i     (spread),
      .ovr_valid_i  (ovr_pend && (ovr_hi == (o == 1))),
      .ovr_num_i    (ovr_num),
      .valid_o      (win_valid[o]),
      .num_o        (win_num[o])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vec_lo_q <= '0;
      vec_hi_q <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      vec_lo_q <= win_num[0];
      vec_hi_q <= win_num[1];
      irq_lo_q <= win_valid[0];
      irq_hi_q <= win_valid[1];
    end
  end

  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;
endmodule

// File: rtl/qgic_check.sv
module qgic_check #(
  parameter int NUM_SRC = 48,
  parameter int VEC_W   = 6
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [VEC_W-1:0]   ovr_num_i,
  input logic               ovr_hi_i,
  input logic [VEC_W-1:0]   vec_lo_i,
  input logic [VEC_W-1:0]   vec_hi_i,
  input logic               irq_lo_i,
  input logic               irq_hi_i
);
  logic [NUM_SRC-1:0] pend_q;
  logic               ovr_live;

  always_ff @(posedge clk_i) pend_q <= pend_i;

  assign ovr_live = (ovr_num_i != '0) && (int'(ovr_num_i) <= NUM_SRC) &&
                    (((pend_i >> (ovr_num_i - 1'b1)) & NUM_SRC'(1)) != '0);

  // R3: nothing pending last cycle means both outputs idle with zero vectors
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(pend_i) == '0) |-> (!irq_lo_i && !irq_hi_i && vec_lo_i == '0 && vec_hi_i == '0));

  // R2: a reported low source was enabled and asserted in the previous cycle
  p_lo_winner_pending_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_lo_i |-> (vec_lo_i != '0 && ((pend_q >> (vec_lo_i - 1'b1)) & NUM_SRC'(1)) != '0));

  // R2: same for the high output
  p_hi_winner_pending_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_hi_i |-> (vec_hi_i != '0 && ((pend_q >> (vec_hi_i - 1'b1)) & NUM_SRC'(1)) != '0));

  // R7: one source never appears on both outputs
  p_outputs_distinct_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_lo_i && irq_hi_i) |-> (vec_lo_i != vec_hi_i));

  // R8: a pending override owns its chosen output one cycle later
  p_override_hi_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovr_live && ovr_hi_i) |=> (irq_hi_i && vec_hi_i == $past(ovr_num_i)));

  p_override_lo_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovr_live && !ovr_hi_i) |=> (irq_lo_i && vec_lo_i == $past(ovr_num_i)));
endmodule

bind qgic_top qgic_check #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .pend_i    (pend),
  .ovr_num_i (ovr_num),
  .ovr_hi_i  (ovr_hi),
  .vec_lo_i  (vec_lo_q),
  .vec_hi_i  (vec_hi_q),
  .irq_lo_i  (irq_lo_q),
  .irq_hi_i  (irq_hi_q)
);

// File: tb/qgic_top_test.sv
module qgic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic            wr = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq_hi, irq_lo;

  int errors = 0;
  int checks = 0;

  logic [31:0] sh_cfg, sh_main, sh_risc, sh_route;
  logic [31:0] sh_slot [6];

  localparam logic [31:0] SLOT_ID = {24'o01234567, 8'h00};

  qgic_top uut (
    .clk_i(clk), .rst_i(rst), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // expected vector for one output, from the requirements
  function automatic logic [5:0] model(input bit hi);
    logic [NSRC-1:0] pend;
    int  ov;
    bit  ov_hi;
    bit  has [6];
    int  cm [6];
    int  cs [6];
    for (int i = 0; i < NSRC; i++)
      pend[i] = src[i] & ((i < 16) ? sh_risc[i] : sh_main[i-16]);
    ov    = int'(sh_cfg[5:0]);
    ov_hi = (sh_cfg[9:8] == 2'b10);
    if (ov >= 1 && ov <= NSRC && pend[ov-1] && ov_hi == hi) return 6'(ov);
    for (int g = 0; g < 6; g++) begin
      logic [7:0] seen;
      seen = '0; has[g] = 0; cm[g] = 0; cs[g] = 0;
      for (int p = 0; p < 8; p++) begin
        int code, idx;
        bit rh;
        code = int'(sh_slot[g][29-3*p +: 3]);
        idx  = g*8 + code;
        rh   = (p == 0) ? (sh_route[4*g+2 +: 2] == 2'b10) :
               (p == 1) ? (sh_route[4*g +: 2] == 2'b10) : 1'b0;
        if (!has[g] && !seen[code] && pend[idx] && (idx + 1 != ov) && rh == hi) begin
          has[g] = 1; cm[g] = code; cs[g] = p;
        end
        seen[code] = 1'b1;
      end
    end
    for (int g = 0; g < 6; g++)
      if (has[g] && !sh_cfg[16+g]) return 6'(g*8 + cm[g] + 1);
    for (int s = 0; s < 8; s++)
      for (int g = 0; g < 6; g++)
        if (has[g] && sh_cfg[16+g] && cs[g] == s) return 6'(g*8 + cm[g] + 1);
    return 6'd0;
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      0: sh_cfg = d;
      1: sh_main = d;
      2: sh_risc = d;
      3: sh_route = d;
      default: if (a >= 4 && a < 10) sh_slot[a-4] = d;
    endcase
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic check_out(input string tag);
    logic [31:0] d;
    logic [5:0]  elo, ehi;
    repeat (2) @(negedge clk);
    elo = model(1'b0);
    ehi = model(1'b1);
    rd_reg(10, d);
    check_eq({tag, " low vector"}, d, {elo, 26'b0});
    rd_reg(11, d);
    check_eq({tag, " high vector"}, d, {ehi, 26'b0});
    check_eq({tag, " low request"}, {31'b0, irq_lo}, {31'b0, elo != 0});
    check_eq({tag, " high request"}, {31'b0, irq_hi}, {31'b0, ehi != 0});
  endtask

  function automatic logic [31:0] slots3(input int s1, input int s2, input int rest);
    logic [31:0] r;
    r = '0;
    for (int p = 0; p < 8; p++)
      r[29-3*p +: 3] = 3'((p == 0) ? s1 : (p == 1) ? s2 : rest);
    return r;
  endfunction

  initial begin
    logic [31:0] d;
    int seed;
    sh_cfg = '0; sh_main = '0; sh_risc = '0; sh_route = '0;
    for (int g = 0; g < 6; g++) sh_slot[g] = SLOT_ID;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd_reg(0, d);  check_eq("R1 config reset", d, 32'h0);
    rd_reg(1, d);  check_eq("R1 main mask reset", d, 32'h0);
    rd_reg(2, d);  check_eq("R1 risc mask reset", d, 32'h0);
    rd_reg(3, d);  check_eq("R1 route reset", d, 32'h0);
    for (int g = 0; g < 6; g++) begin
      rd_reg(4 + g, d); check_eq("R1 slot identity", d, SLOT_ID);
    end
    check_out("R1 idle");

    // R2: masked sources never reported
    src = '1;
    check_out("R2 all masked");
    wr_reg(2, 32'h0000_0008);
    check_out("R2 risc bit 3");
    wr_reg(2, 32'h0); wr_reg(1, 32'h0000_0001);
    check_out("R2 main bit 0");

    // R4: slot order inside a group, unlisted member ignored
    wr_reg(1, 32'h0000_00FF);
    wr_reg(6, slots3(5, 1, 5));
    check_out("R4 slot1 member");
    src[2*8+5] = 1'b0;
    check_out("R4 slot2 member");
    src = '0; src[2*8+7] = 1'b1;
    check_out("R4 unlisted member");
    wr_reg(6, SLOT_ID);

    // R5: fixed group order
    wr_reg(1, 32'hFFFF_FFFF); wr_reg(2, 32'h0000_FFFF);
    src = '0; src[0*8+2] = 1'b1; src[3*8+0] = 1'b1;
    check_out("R5 group0 before group3");
    wr_reg(0, 32'h0001_0000);
    check_out("R5 spread group after grouped");

    // R6: spread pool ranks by slot
    wr_reg(0, 32'h0009_0000);
    check_out("R6 slot1 beats slot3");
    src[3*8+0] = 1'b0; src[3*8+5] = 1'b1;
    check_out("R6 slot3 beats slot6");
    src[3*8+5] = 1'b0; src[3*8+2] = 1'b1;
    check_out("R6 tie goes to lower group");

    // R7: same-cycle split between outputs
    wr_reg(0, 32'h0);
    src = '0; src[2*8+0] = 1'b1; src[2*8+1] = 1'b1;
    wr_reg(3, 32'h0000_0800);
    check_out("R7 slot1 high slot2 low");
    wr_reg(3, 32'h0000_0C00);
    check_out("R7 code 11 stays low");
    wr_reg(3, 32'h0000_0A00);
    check_out("R7 both slots high");

    // R8: override
    wr_reg(3, 32'h0000_0800);
    src[2*8+1] = 1'b0; src[4*8+7] = 1'b1;
    wr_reg(0, 32'h0000_0228);
    check_out("R8 override high beats slot1");
    wr_reg(0, 32'h0000_0128);
    check_out("R8 override to low");
    wr_reg(0, 32'h0000_0111);
    check_out("R8 override removes group routing");
    wr_reg(0, 32'h0000_0229);
    check_out("R8 idle override ignored");

    // R9 / R10: timing of requests
    wr_reg(0, 32'h0); wr_reg(3, 32'h0);
    src = '0;
    repeat (2) @(negedge clk);
    src[5*8+3] = 1'b1;
    #1 check_eq("R9 no request before edge", {31'b0, irq_lo}, 32'h0);
    @(negedge clk);
    check_eq("R9 request one edge later", {31'b0, irq_lo}, 32'h1);
    repeat (5) @(negedge clk);
    check_eq("R10 request held while level", {31'b0, irq_lo}, 32'h1);
    src[5*8+3] = 1'b0;
    @(negedge clk);
    check_eq("R10 request drops one edge later", {31'b0, irq_lo}, 32'h0);
    src[5*8+3] = 1'b1;
    @(negedge clk); wr = 1'b1; addr = 4'd1; wdata = 32'h0; sh_main = 32'h0;
    @(negedge clk); wr = 1'b0;
    check_eq("R9 mask write not yet seen", {31'b0, irq_lo}, 32'h1);
    @(negedge clk);
    check_eq("R9 mask write effective", {31'b0, irq_lo}, 32'h0);

    // random rounds covering R2..R8
    for (int it = 0; it < 250; it++) begin
      logic [31:0] c;
      wr_reg(1, $urandom);
      wr_reg(2, $urandom & 32'h0000_FFFF);
      wr_reg(3, $urandom & 32'h00FF_FFFF);
      for (int g = 0; g < 6; g++) wr_reg(4 + g, $urandom & 32'hFFFF_FF00);
      c = 32'($urandom_range(0, 50));
      c[9:8] = 2'($urandom);
      c[21:16] = 6'($urandom);
      if (it % 4 == 0) c[21:16] = 6'h0;
      wr_reg(0, c);
      src = {16'($urandom), $urandom};
      check_out("R2-mix random round");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule